// File: doc/BRIEF.md
# Stacked-Band Multilevel PWM Modulator

This block turns a sampled reference value into a multilevel switching pattern. A single up/down counter forms a base triangle. A fixed offset for each band shifts that triangle into its own slice of the reference range, so the block carries a stack of identical carriers that share frequency and phase. Each band has a comparator that drives one gate bit. A registered level index reports how many of those gate bits are high.

Other logic may write the reference into a holding register at any cycle. The working compare value takes the held value only at the triangle valley, so the comparison threshold is constant across each carrier period. With the default settings (ten bands, band height 400, 12-bit reference) the full scale is 4000 counts. At a 50 MHz clock one carrier period lasts 798 cycles, which gives a carrier of about 63 kHz. A smaller band height gives a faster carrier.

Top module: `mlpwm_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block clears the counter to 0, sets the counting direction to up, and clears the held and working reference. From the next edge, `gate_o` and `level_o` read 0.
- R2: The base triangle steps by one count per clock: 0, 1, …, H-1, H-2, …, 1, then 0 again, where H is the band height. One carrier period is 2·(H-1) cycles. The valley is the cycle in which the count is 0.
- R3: `gate_o[k]` is high exactly when the working reference is strictly greater than `count + k·H`. The output is registered, so it reflects the count and working reference of the previous cycle.
- R4: `level_o` equals the number of high bits in `gate_o`, updated in the same cycle. Its range is 0 to the band count.
- R5: When the working reference is at least (k+1)·H, band k stays high for the whole carrier period. When the working reference is at most k·H, band k stays low for the whole carrier period. No short pulse appears in either case.
- R6: A write (`ref_wr` high) stores `ref_data` in the holding register. The working reference takes the held value only in the valley cycle, so a write during a period has no effect on `gate_o` until the period after the next valley.
- R7: A working reference at or above full scale (band count · H), up to the 12-bit maximum, holds every band high and `level_o` at the band count.
- R8: The gate bits always form a thermometer code. Band k high implies that every band below k is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_wr | input | 1 | Write strobe for the reference holding register |
| ref_data | input | 12 | Unsigned reference sample |
| gate_o | output | 10 | One gate bit per carrier band, bit 0 = lowest band |
| level_o | output | 4 | Number of gate bits that are high |

## Verification
The bench runs a small configuration with band height 4, which gives a 6-cycle carrier and a full scale of 40. It sweeps every reference value from 0 to 63, and each value is held for two periods. That covers values exactly on band edges, values inside a band, and values past full scale.

Edge values separate a strict compare from a non-strict one. Values inside a band show whether the triangle climbs and falls in the correct order. Values past full scale expose saturation or wrap errors. Writes placed mid-period show whether the valley-only load is kept.

A high-time count over whole periods checks the triangle's shape independently of its phase. A reset applied during a run checks that the block restarts cleanly.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;
  localparam int DEF_BANDS  = 10;
  localparam int DEF_BAND_H = 400;
  localparam int DEF_REF_W  = 12;

  function automatic int level_width(input int bands);
    return $clog2(bands + 1);
  endfunction
endpackage

// File: rtl/mlpwm_tri_counter.sv
module mlpwm_tri_counter #(
  parameter int BAND_H = 400,
  localparam int CNT_W = (BAND_H > 2) ? $clog2(BAND_H) : 1
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_o,
  output logic             valley_o
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(BAND_H - 1);

  logic [CNT_W-1:0] cnt;
  logic             going_up;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      going_up <= 1'b1;
    end else if (going_up) begin
      if (cnt == TOP) begin
        cnt      <= cnt - CNT_W'(1);
        going_up <= 1'b0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end else begin
      if (cnt == '0) begin
        cnt      <= CNT_W'(1);
        going_up <= 1'b1;
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  assign cnt_o    = cnt;
  assign valley_o = (cnt == '0);

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) <= BAND_H - 1);

  // R2
  unit_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (int'(cnt) == int'($past(cnt)) + 1) || (int'(cnt) == int'($past(cnt)) - 1));

  // R2
  valley_turn_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) |=> (int'(cnt) == 1));
endmodule

// File: rtl/mlpwm_ref_hold.sv
module mlpwm_ref_hold #(
  parameter int REF_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [REF_W-1:0] data_i,
  input  logic             valley_i,
  output logic [REF_W-1:0] work_o
);
  logic [REF_W-1:0] held;
  logic [REF_W-1:0] work;

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= '0;
      work <= '0;
    end else begin
      if (wr_i)     held <= data_i;
      if (valley_i) work <= held;
    end
  end

  assign work_o = work;

  // R6
  work_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valley_i |=> $stable(work));

  // R6
  held_capture_chk: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> held == $past(data_i));
endmodule

// File: rtl/mlpwm_band_cmp.sv
module mlpwm_band_cmp #(
  parameter int BANDS  = 10,
  parameter int BAND_H = 400,
  parameter int REF_W  = 12,
  parameter int CNT_W  = 9,
  parameter int LVL_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [REF_W-1:0] work_i,
  output logic [BANDS-1:0] gate_o,
  output logic [LVL_W-1:0] level_o
);
  localparam int FULL = BANDS * BAND_H;

  logic [BANDS-1:0] hit;
  logic [LVL_W-1:0] hit_count;

  for (genvar k = 0; k < BANDS; k++) begin : g_band
    logic [REF_W-1:0] carrier;
    assign carrier = REF_W'(k * BAND_H) + REF_W'(cnt_i);
    assign hit[k]  = work_i > carrier;
  end

  always_comb begin
    hit_count = '0;
    for (int k = 0; k < BANDS; k++) begin
      hit_count = hit_count + LVL_W'(hit[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_o  <= '0;
      level_o <= '0;
    end else begin
      gate_o  <= hit;
      level_o <= hit_count;
    end
  end

  // R4
  level_match_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> int'(level_o) == $countones(gate_o));

  // R8
  thermo_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $onehot0({1'b0, gate_o} + {{BANDS{1'b0}}, 1'b1}));

  // R7
  full_scale_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(work_i) >= FULL) |=> (&gate_o));

  // R5
  floor_off_chk: assert property (@(posedge clk) disable iff (rst)
    (work_i == '0) |=> (gate_o == '0));
endmodule

// File: rtl/mlpwm_top.sv
module mlpwm_top
  import mlpwm_pkg::*;
#(
  parameter int BANDS  = DEF_BANDS,
  parameter int BAND_H = DEF_BAND_H,
  parameter int REF_W  = DEF_REF_W,
  localparam int CNT_W = (BAND_H > 2) ? $clog2(BAND_H) : 1,
  localparam int LVL_W = level_width(BANDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_wr,
  input  logic [REF_W-1:0] ref_data,
  output logic [BANDS-1:0] gate_o,
  output logic [LVL_W-1:0] level_o
);
  logic [CNT_W-1:0] cnt;
  logic             valley;
  logic [REF_W-1:0] work;

  mlpwm_tri_counter #(.BAND_H(BAND_H)) u_tri (
    .clk      (clk),
    .rst      (rst),
    .cnt_o    (cnt),
    .valley_o (valley)
  );

  mlpwm_ref_hold #(.REF_W(REF_W)) u_ref (
    .clk      (clk),
    .rst      (rst),
    .wr_i     (ref_wr),
    .data_i   (ref_data),
    .valley_i (valley),
    .work_o   (work)
  );

  mlpwm_band_cmp #(
    .BANDS  (BANDS),
    .BAND_H (BAND_H),
    .REF_W  (REF_W),
    .CNT_W  (CNT_W),
    .LVL_W  (LVL_W)
  ) u_cmp (
    .clk     (clk),
    .rst     (rst),
    .cnt_i   (cnt),
    .work_i  (work),
    .gate_o  (gate_o),
    .level_o (level_o)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (gate_o == '0) && (level_o == '0));
endmodule

// File: tb/mlpwm_top_bench.sv
module mlpwm_top_bench;
  localparam int NB   = 10;
  localparam int H    = 4;
  localparam int PER  = 2 * (H - 1);
  localparam int FULL = NB * H;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_wr = 1'b0;
  logic [11:0] ref_data = '0;
  logic [9:0]  gate_o;
  logic [3:0]  level_o;

  int checks = 0;
  int errors = 0;

  int m_cnt = 0;
  bit m_up = 1'b1;
  int m_held = 0;
  int m_work = 0;

  always #10 clk = ~clk;

  mlpwm_top #(.BANDS(NB), .BAND_H(H), .REF_W(12)) u_mlpwm_top (
    .clk      (clk),
    .rst      (rst),
    .ref_wr   (ref_wr),
    .ref_data (ref_data),
    .gate_o   (gate_o),
    .level_o  (level_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (ref=%0d cnt=%0d)", tag, act, exp, m_work, m_cnt);
    end
  endtask

  function automatic int exp_gate(input int w, input int c);
    int g = 0;
    for (int k = 0; k < NB; k++) if (w > c + k * H) g |= (1 << k);
    return g;
  endfunction

  function automatic int exp_level(input int w, input int c);
    int n = 0;
    for (int k = 0; k < NB; k++) if (w > c + k * H) n++;
    return n;
  endfunction

  // one cycle: drive at negedge, advance model, check at next negedge
  task automatic step(input bit wr, input int data);
    int eg, el, w0;
    ref_wr   = wr;
    ref_data = 12'(data);
    eg = exp_gate(m_work, m_cnt);
    el = exp_level(m_work, m_cnt);
    w0 = m_work;
    if (m_cnt == 0) m_work = m_held;
    if (wr) m_held = data;
    if (m_up) begin
      if (m_cnt == H - 1) begin m_cnt--; m_up = 1'b0; end else m_cnt++;
    end else begin
      if (m_cnt == 0) begin m_cnt = 1; m_up = 1'b1; end else m_cnt--;
    end
    @(negedge clk);
    ref_wr = 1'b0;
    check("R3 gate", int'(gate_o), eg);
    check("R4 level", int'(level_o), el);
    for (int k = 0; k < NB; k++) begin
      if (w0 >= (k + 1) * H) check("R5 band held on", int'(gate_o[k]), 1);
      else if (w0 <= k * H)  check("R5 band held off", int'(gate_o[k]), 0);
    end
    if (w0 >= FULL) check("R7 saturate", int'(level_o), NB);
    check("R8 thermometer", int'(((int'(gate_o) + 1) & int'(gate_o)) == 0), 1);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    ref_wr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 gate after reset", int'(gate_o), 0);
    check("R1 level after reset", int'(level_o), 0);
    m_cnt = 0; m_up = 1'b1; m_held = 0; m_work = 0;
    rst = 1'b0;
  endtask

  initial begin
    int hi;
    @(negedge clk);
    do_reset();

    // full sweep of reference values
    for (int r = 0; r < 64; r++) begin
      step(1'b1, r);
      for (int i = 0; i < 2 * PER; i++) step(1'b0, 0);
    end

    // R2: band 0 high time over whole periods with reference 2
    step(1'b1, 2);
    for (int i = 0; i < 2 * PER; i++) step(1'b0, 0);
    hi = 0;
    for (int i = 0; i < 10 * PER; i++) begin
      step(1'b0, 0);
      hi += int'(gate_o[0]);
    end
    check("R2 band0 high cycles", hi, 30);

    // R6: mid-period write must wait for the valley
    step(1'b1, 5);
    for (int i = 0; i < 2 * PER; i++) step(1'b0, 0);
    while (m_cnt != 2) step(1'b0, 0);
    step(1'b1, 30);
    check("R6 no early update", int'(level_o <= 4'd2), 1);
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 0);
      check("R6 still old value", int'(level_o <= 4'd2), 1);
    end
    for (int i = 0; i < PER; i++) step(1'b0, 0);
    check("R6 new value applied", int'(level_o >= 4'd7), 1);

    // R1: reset mid-run, with a write pending
    step(1'b1, 63);
    do_reset();
    for (int i = 0; i < 2 * PER; i++) step(1'b0, 0);
    check("R1 held ref cleared", int'(gate_o), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule